// File: doc/BRIEF.md
# Magic Packet Wake Event Controller

This block handles wake-on-LAN events inside a network controller. An upstream frame matcher sends a one-cycle strobe each time it recognises a wake frame. If the block is armed when the strobe arrives, it sets three sticky status flags. It issues a discard pulse so the frame never reaches the receive path. It also suspends transmit and receive descriptor polling. From the flags and the host enable bits it drives a power-management event (PME) output, an interrupt output and four LED pins. Each LED has a programmable source and polarity.

The block is armed when the host mode bit is set, power-good is low, and power-good has stayed low for a guard window since it was last high. The guard window is 200 ns, counted in clock cycles. Polling stays suspended until the mode is exited, either by power-good rising or by the host clearing the mode bit. After that, polling resumes from the saved descriptor positions. Only a host re-initialisation returns those positions to zero.

Top module: `wake_event_ctrl`

## Requirements
- R1: A strobe on `frame_hit` while armed sets `match_flag`, `irq_pend` and `pme_stat` at the next clock edge.
- R2: Each flag is cleared by a one-cycle pulse on its clear input (write-one-to-clear). A strobe while armed in the same cycle as a clear leaves the flag set.
- R3: Armed means `mode_en`=1, `power_good`=0 and the guard window expired. A strobe while not armed changes no flag, gives no discard and does not set suspend.
- R4: `pme_out` is 1 exactly when `pme_stat` is 1 and either `pme_en` or `pme_ovr` is 1.
- R5: `irq_out` is 1 exactly when `irq_pend`, `irq_glb_en` and `irq_mp_en` are all 1.
- R6: For each LED i: if `led_sel[i]`=1 and `match_flag`=1, `led_out[i]` shows the active level, otherwise the idle level. The active level is 1 when `led_pol[i]`=1 and 0 when `led_pol[i]`=0. The idle level is the opposite.
- R7: `discard` is 1 in the same cycle as a strobe while armed, and 0 in every other cycle.
- R8: `suspend` rises one edge after a strobe while armed. It stays 1 until a cycle in which `power_good`=1 or `mode_en`=0, and is 0 after that edge.
- R9: `rx_pos` and `tx_pos` increment modulo 2^RING_BITS on `rx_adv`/`tx_adv`, and hold while `suspend`=1. `host_reinit` sets both to 0 and takes priority over an advance.
- R10: After `power_good` was high, the block re-arms only once `power_good` has been low for GUARD_CYC consecutive edges (50 at 250 MHz, which is 200 ns). Any reassertion of `power_good` restarts the count.
- R11: Exiting by clearing `mode_en` keeps no guard. Setting `mode_en` again re-arms in the same cycle, provided `power_good` is low and the guard has already expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_hit | input | 1 | One-cycle wake frame detect strobe |
| power_good | input | 1 | System power-good |
| mode_en | input | 1 | Host wake mode enable |
| pme_en | input | 1 | PME enable |
| pme_ovr | input | 1 | PME enable override |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_mp_en | input | 1 | Wake interrupt enable |
| led_sel | input | NUM_LEDS | Per-LED wake source select |
| led_pol | input | NUM_LEDS | Per-LED polarity, 1 = active high |
| clr_match | input | 1 | Clear `match_flag` |
| clr_irq | input | 1 | Clear `irq_pend` |
| clr_pme | input | 1 | Clear `pme_stat` |
| host_reinit | input | 1 | Reset descriptor positions |
| rx_adv | input | 1 | Advance receive descriptor position |
| tx_adv | input | 1 | Advance transmit descriptor position |
| match_flag | output | 1 | Sticky wake frame seen |
| irq_pend | output | 1 | Sticky interrupt pending |
| pme_stat | output | 1 | Sticky PME status |
| pme_out | output | 1 | PME event output |
| irq_out | output | 1 | Interrupt output |
| led_out | output | NUM_LEDS | LED pins |
| discard | output | 1 | Drop the current frame |
| suspend | output | 1 | Descriptor polling halted |
| armed | output | 1 | Wake mode armed |
| rx_pos | output | RING_BITS | Receive descriptor position |
| tx_pos | output | RING_BITS | Transmit descriptor position |

## Verification
The bench drives power-good blips in the middle of the guard count and strobes at the last guarded cycle and at the first armed cycle. A counter that does not restart, or that is one cycle short, then shows up as an early discard. It places a clear in the same cycle as a strobe, where a design that gives priority to the clear loses the event. It asserts advance strobes during suspend and re-initialisation during an advance, which exposes a design that loses or moves the saved positions. It also tries each LED polarity and source with the PME and interrupt enables set one at a time, so that an inverted polarity or a missing override term cannot go unnoticed.

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl #(
  parameter int CLK_MHZ   = 250,
  parameter int GUARD_NS  = 200,
  parameter int NUM_LEDS  = 4,
  parameter int RING_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_hit,
  input  logic                 power_good,
  input  logic                 mode_en,
  input  logic                 pme_en,
  input  logic                 pme_ovr,
  input  logic                 irq_glb_en,
  input  logic                 irq_mp_en,
  input  logic [NUM_LEDS-1:0]  led_sel,
  input  logic [NUM_LEDS-1:0]  led_pol,
  input  logic                 clr_match,
  input  logic                 clr_irq,
  input  logic                 clr_pme,
  input  logic                 host_reinit,
  input  logic                 rx_adv,
  input  logic                 tx_adv,
  output logic                 match_flag,
  output logic                 irq_pend,
  output logic                 pme_stat,
  output logic                 pme_out,
  output logic                 irq_out,
  output logic [NUM_LEDS-1:0]  led_out,
  output logic                 discard,
  output logic                 suspend,
  output logic                 armed,
  output logic [RING_BITS-1:0] rx_pos,
  output logic [RING_BITS-1:0] tx_pos
);
  localparam int GUARD_CYC = (CLK_MHZ * GUARD_NS + 999) / 1000;
  localparam int GW        = $clog2(GUARD_CYC + 1);

  logic [GW-1:0] guard_cnt;
  logic          hit;

  assign armed   = mode_en && !power_good && (guard_cnt == '0);
  assign hit     = frame_hit && armed;
  assign discard = hit;
  assign pme_out = pme_stat && (pme_en || pme_ovr);
  assign irq_out = irq_pend && irq_glb_en && irq_mp_en;

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    assign led_out[i] = (led_sel[i] && match_flag) ? led_pol[i] : !led_pol[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      guard_cnt <= '0;
    else if (power_good)
      guard_cnt <= GW'(GUARD_CYC);
    else if (guard_cnt != '0)
      guard_cnt <= guard_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
      irq_pend   <= 1'b0;
      pme_stat   <= 1'b0;
      suspend    <= 1'b0;
    end else begin
      match_flag <= hit || (match_flag && !clr_match);
      irq_pend   <= hit || (irq_pend && !clr_irq);
      pme_stat   <= hit || (pme_stat && !clr_pme);
      suspend    <= hit || (suspend && mode_en && !power_good);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pos <= '0;
      tx_pos <= '0;
    end else if (host_reinit) begin
      rx_pos <= '0;
      tx_pos <= '0;
    end else if (!suspend) begin
      if (rx_adv) rx_pos <= rx_pos + 1'b1;
      if (tx_adv) tx_pos <= tx_pos + 1'b1;
    end
  end

  // R1
  flags_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hit && armed |=> match_flag && irq_pend && pme_stat);
  // R2
  hit_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hit && armed && clr_match |=> match_flag);
  // R3
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hit && !armed && !match_flag |=> !match_flag);
  // R4
  pme_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pme_stat && pme_ovr |-> pme_out);
  // R8
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend && mode_en && !power_good |=> suspend);
  // R9
  pos_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend && !host_reinit |=> $stable(rx_pos) && $stable(tx_pos));
  // R10
  guard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_good |=> !armed);
endmodule

// File: tb/wake_event_ctrl_tb.sv
module wake_event_ctrl_tb;
  localparam int NL = 4;
  localparam int RB = 4;
  localparam int GC = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_hit = 0, power_good = 0, mode_en = 0, pme_en = 0, pme_ovr = 0;
  logic irq_glb_en = 0, irq_mp_en = 0, clr_match = 0, clr_irq = 0, clr_pme = 0;
  logic host_reinit = 0, rx_adv = 0, tx_adv = 0;
  logic [NL-1:0] led_sel = '0, led_pol = '0;
  logic match_flag, irq_pend, pme_stat, pme_out, irq_out, discard, suspend, armed;
  logic [NL-1:0] led_out;
  logic [RB-1:0] rx_pos, tx_pos;

  int checks = 0, failures = 0;
  int m_match = 0, m_irq = 0, m_pme = 0, m_susp = 0, m_cnt = 0, m_rx = 0, m_tx = 0;

  always #2 clk = ~clk;

  wake_event_ctrl u_dut (.*);

  function automatic int m_armed();
    return (mode_en && !power_good && m_cnt == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_match = 0; m_irq = 0; m_pme = 0; m_susp = 0; m_cnt = 0; m_rx = 0; m_tx = 0;
    end else begin
      int h;
      h = frame_hit && m_armed();
      m_match = (h || (m_match && !clr_match)) ? 1 : 0;
      m_irq   = (h || (m_irq && !clr_irq)) ? 1 : 0;
      m_pme   = (h || (m_pme && !clr_pme)) ? 1 : 0;
      if (host_reinit) begin m_rx = 0; m_tx = 0; end
      else if (!m_susp) begin
        if (rx_adv) m_rx = (m_rx + 1) % (1 << RB);
        if (tx_adv) m_tx = (m_tx + 1) % (1 << RB);
      end
      m_susp = (h || (m_susp && mode_en && !power_good)) ? 1 : 0;
      if (power_good) m_cnt = GC; else if (m_cnt > 0) m_cnt = m_cnt - 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R1 match_flag", match_flag, m_match);
    chk("R2 irq_pend", irq_pend, m_irq);
    chk("R1 pme_stat", pme_stat, m_pme);
    chk("R10 R11 armed", armed, m_armed());
    chk("R4 pme_out", pme_out, m_pme && (pme_en || pme_ovr));
    chk("R5 irq_out", irq_out, m_irq && irq_glb_en && irq_mp_en);
    chk("R7 R3 discard", discard, frame_hit && m_armed());
    chk("R8 suspend", suspend, m_susp);
    chk("R9 rx_pos", rx_pos, m_rx);
    chk("R9 tx_pos", tx_pos, m_tx);
    for (int i = 0; i < NL; i++)
      chk("R6 led_out", led_out[i], (led_sel[i] && m_match) ? led_pol[i] : !led_pol[i]);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe();
    frame_hit = 1; step(1); frame_hit = 0;
  endtask

  task automatic clear_all();
    clr_match = 1; clr_irq = 1; clr_pme = 1; step(1);
    clr_match = 0; clr_irq = 0; clr_pme = 0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1; step(2);
    // R3: not armed, strobe ignored
    strobe(); step(2);
    // R9: advance while running
    rx_adv = 1; tx_adv = 1; step(3); tx_adv = 0; step(2); rx_adv = 0;
    mode_en = 1; pme_en = 1; irq_glb_en = 1; irq_mp_en = 1;
    led_sel = 4'b0100; led_pol = 4'b0101; step(1);
    // R1 R7 R8
    strobe(); step(2);
    // R9 freeze while suspended
    rx_adv = 1; tx_adv = 1; step(4); rx_adv = 0; tx_adv = 0;
    // R4 R5 gating
    pme_en = 0; step(1); pme_ovr = 1; step(1); pme_ovr = 0; irq_mp_en = 0; step(1);
    irq_mp_en = 1; led_pol = 4'b1010; step(1);
    // R8 exit by power_good, R10 guard
    power_good = 1; step(3); power_good = 0; step(10);
    rx_adv = 1; step(2); rx_adv = 0;
    strobe(); step(20);
    power_good = 1; step(1); power_good = 0;   // R10 restart
    step(GC - 1); strobe();                    // last guarded cycle
    strobe(); step(2);                         // first armed cycle
    // R2 clear alone and clear vs hit
    clear_all(); step(1);
    clr_match = 1; frame_hit = 1; step(1); clr_match = 0; frame_hit = 0; step(1);
    // R11 exit by mode_en, immediate re-arm
    mode_en = 0; step(2); strobe(); mode_en = 1; strobe(); step(2);
    // R9 reinit with advance
    host_reinit = 1; rx_adv = 1; step(1); host_reinit = 0; step(1); rx_adv = 0;
    mode_en = 0; step(1); host_reinit = 1; step(1); host_reinit = 0; mode_en = 1;
    clear_all();
    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom % 64;
      frame_hit  = (r % 7 == 0);
      power_good = (r == 5) ? ~power_good : (k % 400 == 399 ? 1'b0 : power_good);
      if (r == 9) mode_en = ~mode_en;
      clr_match = (r % 11 == 0); clr_irq = (r % 13 == 0); clr_pme = (r % 17 == 0);
      rx_adv = r[0]; tx_adv = r[1];
      host_reinit = (r == 33);
      pme_en = r[2]; pme_ovr = r[3] & r[4]; irq_glb_en = r[5] | r[2]; irq_mp_en = r[3] | r[1];
      if (r == 12) led_sel = 4'(r >> 2) ^ led_sel;
      if (r == 20) led_pol = ~led_pol;
      step(1);
    end
    frame_hit = 0; power_good = 0; step(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule